// File: doc/BRIEF.md
# Manchester Bit-Period Drift Compensator

This block keeps a receiver's bit clock locked to a Manchester-coded line that drifts slowly against the local oversampling clock. It counts oversampling ticks through each bit. It compares the tick on which the mid-bit transition arrives with the tick on which that transition was due, at the bit centre. It then stretches or shrinks only the current bit by a single tick. Small offsets are treated as jitter and produce no correction. Offsets of moderate size are treated as drift and corrected. Larger offsets inside the observation span are reported as synchronization errors. Transitions near the bit boundary carry no timing information here and are ignored.

A frame starts with a one-clock `sof` pulse. The first line transition after it fixes the phase: that transition is taken to sit at the bit centre. From then on the block emits a `bit_tick` at the end of every bit and a `sample_stb` at the quarter point. It also emits one classification pulse for each bit in which a transition was judged. Correction needs the 16x ratio and the `comp_en` input. In 8x mode, or with `comp_en` low, the period is fixed and no classification is made. The interface is control-only: there is no data stream, so nothing can be held back and no valid/ready handshake exists. All pins are plain, and `os_en` alone paces the block.

Top module: `mdc_drift_comp`

## Requirements
- R1: After reset and until the first `sof`, every output stays low.
- R2: After `sof`, the first line transition seen on an `os_en` cycle sets the bit phase to the centre, tick 8 of 16 (4 of 8 in 8x mode). The first `bit_tick` then falls on the 8th `os_en` cycle after that transition (the 4th in 8x mode).
- R3: With `comp_en` low in 16x mode, every bit lasts 16 `os_en` cycles whatever the edge timing, and no classification pulse is raised.
- R4: With `osr_x8` high, every bit lasts 8 `os_en` cycles and no classification pulse is raised, even with `comp_en` high.
- R5: An edge's offset is the index k of its `os_en` cycle counted from 1 after the last `bit_tick`, minus 9. An offset of -1, 0 or +1 raises `edge_jitter` and leaves the bit at 16 cycles.
- R6: An offset of -4, -3 or -2 raises `edge_early` and shortens that bit to 15 cycles.
- R7: An offset of +2 or +3 raises `edge_late` and lengthens that bit to 17 cycles.
- R8: An offset of -6, -5, +4 or +5 raises `sync_err` and leaves the bit at 16 cycles.
- R9: Edges with offsets outside -6..+5 are ignored. So is any edge after the first classified one in the same bit. Such edges change no output.
- R10: The bit after a corrected bit is back to 16 cycles unless it carries its own correction.
- R11: `sample_stb` is high on the `os_en` cycle that is 4 cycles into the bit (2 in 8x mode), counting from 0 after `bit_tick`. It is never high together with `bit_tick`.
- R12: Each classification output is a one-clock pulse, one clock after the `os_en` cycle that sampled the edge. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_en | input | 1 | Oversampling tick enable |
| rxd | input | 1 | Synchronized receive line |
| comp_en | input | 1 | Enables drift correction and classification |
| osr_x8 | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| sof | input | 1 | Start of frame: re-arms phase capture |
| bit_tick | output | 1 | Last oversampling tick of a bit (combinational with `os_en`) |
| sample_stb | output | 1 | Sampling point of a bit (combinational with `os_en`) |
| edge_jitter | output | 1 | Edge within jitter tolerance |
| edge_early | output | 1 | Early drift, bit shortened |
| edge_late | output | 1 | Late drift, bit lengthened |
| sync_err | output | 1 | Edge outside both drift windows |

## Verification
`bit_tick` and `sample_stb` are due in the same clock as the qualifying `os_en`. The four classification pulses are due one clock after the `os_en` cycle that sampled the edge. A bit's length can only be seen at the following `bit_tick`, which comes up to 17 oversampling ticks later. The bench drives its inputs on the falling edge and samples just after it, against a behavioural model that advances on the rising edge. This puts the combinational outputs and the registered pulses in the same sampling slot the design uses. Bit lengths are measured as gaps between observed ticks and are checked only once the tick closing the stimulated bit has been seen.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} mdc_state_e;
  typedef enum logic [2:0] {CL_NONE, CL_JIT, CL_EARLY, CL_LATE, CL_ERR} mdc_cls_e;
endpackage

// File: rtl/mdc_edge_det.sv
module mdc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic os_en,
  input  logic rxd,
  output logic edge_o
);
  logic rxd_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     rxd_q <= 1'b1;
    else if (os_en) rxd_q <= rxd;
  end

  assign edge_o = os_en && (rxd != rxd_q);
endmodule

// File: rtl/mdc_window_cls.sv
module mdc_window_cls
  import mdc_pkg::*;
#(
  parameter int PW       = 5,
  parameter int JIT_TOL  = 1,
  parameter int EARLY_LO = 2,
  parameter int EARLY_HI = 4,
  parameter int LATE_LO  = 2,
  parameter int LATE_HI  = 3,
  parameter int OBS_PRE  = 6,
  parameter int OBS_POST = 5
) (
  input  logic              active,
  input  logic signed [PW:0] offset,
  output mdc_cls_e          cls
);
  int o;

  always_comb begin
    o = int'(offset);
    if (!active)                                 cls = CL_NONE;
    else if (o >= -JIT_TOL && o <= JIT_TOL)      cls = CL_JIT;
    else if (o >= -EARLY_HI && o <= -EARLY_LO)   cls = CL_EARLY;
    else if (o >= LATE_LO && o <= LATE_HI)       cls = CL_LATE;
    else if (o >= -OBS_PRE && o <= OBS_POST)     cls = CL_ERR;
    else                                         cls = CL_NONE;
  end
endmodule

// File: rtl/mdc_phase_ctr.sv
module mdc_phase_ctr #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          step,
  input  logic          adj_dn,
  input  logic          adj_up,
  input  logic [PW-1:0] nom_last,
  input  logic [PW-1:0] centre,
  output logic [PW-1:0] ph,
  output logic [PW-1:0] last,
  output logic          wrap
);
  assign wrap = (ph == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= '0;
      last <= '0;
    end else if (clr) begin
      ph   <= '0;
      last <= nom_last;
    end else if (load) begin
      ph   <= centre;
      last <= nom_last;
    end else if (step) begin
      if (wrap) begin
        ph   <= '0;
        last <= nom_last;
      end else begin
        ph <= ph + 1'b1;
        if (adj_dn)      last <= nom_last - 1'b1;
        else if (adj_up) last <= nom_last + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdc_drift_comp.sv
module mdc_drift_comp
  import mdc_pkg::*;
#(
  parameter int OSR_HI   = 16,
  parameter int OSR_LO   = 8,
  parameter int JIT_TOL  = 1,
  parameter int EARLY_LO = 2,
  parameter int EARLY_HI = 4,
  parameter int LATE_LO  = 2,
  parameter int LATE_HI  = 3,
  parameter int OBS_PRE  = 6,
  parameter int OBS_POST = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_en,
  input  logic rxd,
  input  logic comp_en,
  input  logic osr_x8,
  input  logic sof,
  output logic bit_tick,
  output logic sample_stb,
  output logic edge_jitter,
  output logic edge_early,
  output logic edge_late,
  output logic sync_err
);
  localparam int PW = $clog2(OSR_HI + 2);
  localparam logic [PW-1:0] LAST_HI = PW'(OSR_HI - 1);
  localparam logic [PW-1:0] LAST_LO = PW'(OSR_LO - 1);
  localparam logic [PW-1:0] CTR_HI  = PW'(OSR_HI / 2);
  localparam logic [PW-1:0] CTR_LO  = PW'(OSR_LO / 2);
  localparam logic [PW-1:0] SMP_HI  = PW'(OSR_HI / 4);
  localparam logic [PW-1:0] SMP_LO  = PW'(OSR_LO / 4);

  mdc_state_e       st;
  mdc_cls_e         cls;
  logic             edge_s, seen, running, step, load, hit, wrap, comp_act;
  logic [PW-1:0]    ph, last, nom_last, centre, smp;
  logic signed [PW:0] offset;

  assign nom_last = osr_x8 ? LAST_LO : LAST_HI;
  assign centre   = osr_x8 ? CTR_LO  : CTR_HI;
  assign smp      = osr_x8 ? SMP_LO  : SMP_HI;
  assign comp_act = comp_en && !osr_x8;
  assign running  = (st == ST_RUN);
  assign step     = running && os_en;
  assign load     = (st == ST_ARM) && edge_s && !sof;
  assign offset   = $signed({1'b0, ph}) - $signed({1'b0, centre});
  assign hit      = step && edge_s && !sof && (cls != CL_NONE);

  mdc_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .os_en(os_en), .rxd(rxd), .edge_o(edge_s)
  );

  mdc_window_cls #(
    .PW(PW), .JIT_TOL(JIT_TOL), .EARLY_LO(EARLY_LO), .EARLY_HI(EARLY_HI),
    .LATE_LO(LATE_LO), .LATE_HI(LATE_HI), .OBS_PRE(OBS_PRE), .OBS_POST(OBS_POST)
  ) u_cls (
    .active(comp_act && running && !seen), .offset(offset), .cls(cls)
  );

  mdc_phase_ctr #(.PW(PW)) u_ph (
    .clk(clk), .rst_n(rst_n), .clr(sof), .load(load), .step(step),
    .adj_dn(hit && cls == CL_EARLY), .adj_up(hit && cls == CL_LATE),
    .nom_last(nom_last), .centre(centre), .ph(ph), .last(last), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 st <= ST_IDLE;
    else if (sof)               st <= ST_ARM;
    else if (load)              st <= ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 seen <= 1'b0;
    else if (sof || load)       seen <= 1'b0;
    else if (step && wrap)      seen <= 1'b0;
    else if (hit)               seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_jitter <= 1'b0;
      edge_early  <= 1'b0;
      edge_late   <= 1'b0;
      sync_err    <= 1'b0;
    end else begin
      edge_jitter <= hit && (cls == CL_JIT);
      edge_early  <= hit && (cls == CL_EARLY);
      edge_late   <= hit && (cls == CL_LATE);
      sync_err    <= hit && (cls == CL_ERR);
    end
  end

  assign bit_tick   = step && wrap;
  assign sample_stb = step && (ph == smp);
endmodule

// File: rtl/mdc_drift_comp_sva.sv
module mdc_drift_comp_sva (
  input logic clk,
  input logic rst_n,
  input logic os_en,
  input logic rxd,
  input logic comp_en,
  input logic osr_x8,
  input logic sof,
  input logic bit_tick,
  input logic sample_stb,
  input logic edge_jitter,
  input logic edge_early,
  input logic edge_late,
  input logic sync_err
);
  logic any_flag;
  assign any_flag = edge_jitter | edge_early | edge_late | sync_err;

  AST_TICK_ON_OSEN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_en); // R3
  AST_STB_ON_OSEN: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> os_en); // R11
  AST_STB_NOT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_tick)); // R11
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({edge_jitter, edge_early, edge_late, sync_err})); // R12
  AST_FLAG_AFTER_OSEN: assert property (@(posedge clk) disable iff (!rst_n)
    any_flag |-> $past(os_en)); // R12
  AST_FLAG_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    any_flag |=> !any_flag); // R12
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(comp_en && !osr_x8) |-> !any_flag); // R4
endmodule

bind mdc_drift_comp mdc_drift_comp_sva u_sva (.*);

// File: tb/mdc_drift_comp_test.sv
`timescale 1ns/1ps
module mdc_drift_comp_test;
  logic clk = 1'b0, rst_n = 1'b0, os_en = 1'b0, rxd = 1'b1;
  logic comp_en = 1'b0, osr_x8 = 1'b0, sof = 1'b0;
  logic bit_tick, sample_stb, edge_jitter, edge_early, edge_late, sync_err;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mdc_drift_comp uut (.*);

  // oversampling enable every other clock
  initial forever begin
    @(negedge clk);
    cyc++;
    os_en = (cyc % 2 == 0);
  end

  // behavioural reference
  int mst = 0, mph = 0, mlast = 0, mseen = 0, mprev = 1;
  int mj = 0, me = 0, ml = 0, mr = 0;
  int nl, cen, off, c;
  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mph = 0; mlast = 0; mseen = 0; mprev = 1;
      mj = 0; me = 0; ml = 0; mr = 0;
    end else begin
      nl  = osr_x8 ? 7 : 15;
      cen = osr_x8 ? 4 : 8;
      mj = 0; me = 0; ml = 0; mr = 0;
      if (sof) begin
        mst = 1; mph = 0; mlast = nl; mseen = 0;
      end else if (mst == 1 && os_en && rxd != mprev) begin
        mst = 2; mph = cen; mlast = nl; mseen = 0;
      end else if (mst == 2 && os_en) begin
        c = 0;
        off = mph - cen;
        if (rxd != mprev && mseen == 0 && comp_en && !osr_x8) begin
          if (off >= -1 && off <= 1)        c = 1;
          else if (off <= -2 && off >= -4)  c = 2;
          else if (off >= 2 && off <= 3)    c = 3;
          else if (off >= -6 && off <= 5)   c = 4;
        end
        if (mph == mlast) begin
          mph = 0; mlast = nl; mseen = 0;
        end else begin
          mph++;
          if (c == 2) mlast = nl - 1;
          if (c == 3) mlast = nl + 1;
          if (c != 0) mseen = 1;
        end
        mj = (c == 1); me = (c == 2); ml = (c == 3); mr = (c == 4);
      end
      if (os_en) mprev = rxd;
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison and monitors
  int since = 0, last_gap = 0, have_tick = 0;
  int n_j = 0, n_e = 0, n_l = 0, n_r = 0;
  int x_tick, x_stb;
  always @(negedge clk) begin
    #1;
    x_tick = (mst == 2 && os_en && mph == mlast);
    x_stb  = (mst == 2 && os_en && mph == (osr_x8 ? 2 : 4));
    chk(bit_tick == x_tick, "R3 bit_tick", bit_tick, x_tick);
    chk(sample_stb == x_stb, "R11 sample_stb", sample_stb, x_stb);
    chk(edge_jitter == mj, "R5/R12 edge_jitter", edge_jitter, mj);
    chk(edge_early == me, "R6/R12 edge_early", edge_early, me);
    chk(edge_late == ml, "R7/R12 edge_late", edge_late, ml);
    chk(sync_err == mr, "R8/R12 sync_err", sync_err, mr);
    n_j += edge_jitter; n_e += edge_early; n_l += edge_late; n_r += sync_err;
    if (sof) begin
      have_tick = 0; since = 0;
    end else if (os_en) begin
      if (sample_stb && have_tick)
        chk(since == (osr_x8 ? 2 : 4), "R11 strobe position", since, osr_x8 ? 2 : 4);
      if (bit_tick) begin
        last_gap = since + 1; since = 0; have_tick = 1;
      end else since++;
    end
  end

  task automatic next_os();
    do begin @(negedge clk); #2; end while (!os_en);
    @(posedge clk);
  endtask

  task automatic wait_tick();
    do begin @(negedge clk); #2; end while (!(os_en && bit_tick));
    @(posedge clk);
  endtask

  // toggle rxd so that the k-th os_en cycle from here samples it
  task automatic put_edge(input int k);
    for (int i = 1; i < k; i++) next_os();
    @(negedge clk);
    rxd = ~rxd;
  endtask

  task automatic start_frame(input int exp_first, input string tag);
    int n;
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    @(negedge clk); rxd = ~rxd;
    #2; n = 0;
    forever begin
      if (os_en) begin
        n++;
        if (bit_tick) break;
      end
      @(negedge clk); #2;
    end
    @(posedge clk);
    chk(n - 1 == exp_first, tag, n - 1, exp_first);
  endtask

  // o = 99 means no edge; exp_cls 0 none, 1 jitter, 2 early, 3 late, 4 error
  task automatic bit_case(input int o, input int o2, input int ctr, input int exp_gap,
                          input int exp_cls, input string tag);
    int j0, e0, l0, r0;
    j0 = n_j; e0 = n_e; l0 = n_l; r0 = n_r;
    if (o != 99) put_edge(ctr + 1 + o);
    if (o2 != 99) put_edge(o2 - o);
    wait_tick();
    chk(last_gap == exp_gap, {tag, " bit length"}, last_gap, exp_gap);
    chk(n_j - j0 == (exp_cls == 1) && n_e - e0 == (exp_cls == 2) &&
        n_l - l0 == (exp_cls == 3) && n_r - r0 == (exp_cls == 4),
        {tag, " class"}, (n_j-j0)+2*(n_e-e0)+3*(n_l-l0)+4*(n_r-r0), exp_cls);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) begin
      @(negedge clk); #2;
      chk({bit_tick, sample_stb, edge_jitter, edge_early, edge_late, sync_err} == 6'b0,
          "R1 idle outputs", {bit_tick, sample_stb, edge_jitter, edge_early, edge_late, sync_err}, 0);
    end
    // 16x with correction
    comp_en = 1'b1; osr_x8 = 1'b0;
    start_frame(8, "R2 first tick 16x");
    bit_case(0,  99, 8, 16, 1, "R5 offset 0");
    bit_case(-3, 99, 8, 15, 2, "R6 offset -3");
    bit_case(99, 99, 8, 16, 0, "R10 back to nominal");
    bit_case(2,  99, 8, 17, 3, "R7 offset +2");
    bit_case(99, 99, 8, 16, 0, "R10 after stretch");
    bit_case(3,  99, 8, 17, 3, "R7 offset +3");
    bit_case(-4, 99, 8, 15, 2, "R6 offset -4");
    bit_case(-2, 99, 8, 15, 2, "R6 offset -2");
    bit_case(-1, 99, 8, 16, 1, "R5 offset -1");
    bit_case(1,  99, 8, 16, 1, "R5 offset +1");
    bit_case(-5, 99, 8, 16, 4, "R8 offset -5");
    bit_case(4,  99, 8, 16, 4, "R8 offset +4");
    bit_case(-6, 99, 8, 16, 4, "R8 offset -6");
    bit_case(5,  99, 8, 16, 4, "R8 offset +5");
    bit_case(-7, 99, 8, 16, 0, "R9 offset -7 ignored");
    bit_case(6,  99, 8, 16, 0, "R9 offset +6 ignored");
    bit_case(0,  2,  8, 16, 1, "R9 second edge ignored");
    bit_case(-3, 3,  8, 15, 2, "R9 second edge after early");
    // correction disabled
    comp_en = 1'b0;
    start_frame(8, "R2 first tick restart");
    bit_case(-3, 99, 8, 16, 0, "R3 disabled early");
    bit_case(2,  99, 8, 16, 0, "R3 disabled late");
    // 8x mode, correction requested but inactive
    comp_en = 1'b1; osr_x8 = 1'b1;
    start_frame(4, "R4 first tick 8x");
    bit_case(-2, 99, 4, 8, 0, "R4 8x early");
    bit_case(2,  99, 4, 8, 0, "R4 8x late");
    bit_case(0,  99, 4, 8, 0, "R4 8x centre");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule